// File: doc/BRIEF.md
# Descriptor Engine Control and Status Registers

This block is the register file and state tracker that sits between a 32-bit register bus and a descriptor-driven crypto engine. Software writes a descriptor address to start the engine, programs throttle, burst and interrupt-enable settings, and issues self-clearing commands to reset the engine, acknowledge the interrupt, acknowledge errors, pick a run mode or request a single step. The block hands the descriptor address to the descriptor walker with a one-cycle start pulse. It then follows the walker's progress, and it receives done, error and fault pulses from the engine.

The engine state is kept in a 3-bit field (idle, busy, error, fault, complete), and the completion code sets bit 2. A level interrupt is raised while interrupts are enabled and the engine waits in the complete, error or fault state. On an error, the raw cause fields from the engine are packed into a multi-field error-status word. DMA details and processing-unit details are kept only when the error source calls for them. A descriptor address written while the engine is occupied is parked in a single holding slot. It is launched on its own once the pending result has been acknowledged.

Top module: `accel_csr`

## Requirements
- R1: Offset 0x00 reads the constant VERSION (default 3). The mapped offsets are 0x04 descriptor address, 0x08 control, 0x0C command, 0x10 status, 0x14 error status, 0x18 fault address, 0x1C current descriptor, 0x20 initial descriptor. Any other offset reads zero.
- R2: After rst_n is held low, the status word reads 0x0002_0000 (idle, dedicated mode) when eng_active and eng_istate are zero. The error status, fault address, control and descriptor registers read zero, and irq is low.
- R3: Only these control fields are writable: throttle in bits 31:24, burst in 23:16, auto-reseed in bit 7, and interrupt enable in bit 4. All other control bits read zero. The fields drive ctl_throttle, ctl_burst and ctl_reseed.
- R4: A write to 0x04 while idle with the holding slot empty moves the state to busy (1) at that clock edge and pulses eng_start for one cycle. eng_desc, 0x20 and 0x1C all equal the written address.
- R5: While busy, eng_next_valid loads eng_next_addr into 0x1C, and 0x20 keeps its value.
- R6: While busy, eng_done moves the state to complete (4), and eng_err moves it to error (2). eng_fault moves it to fault (3). Fault takes priority over error, and error over done. Status bit 4 is set in the error and fault states.
- R7: irq is high exactly when control bit 4 is set and the state is 2, 3 or 4. A command write with bit 8 or bit 9 set returns those states to idle. The same write made while busy has no effect on the state.
- R8: The command register always reads zero. Command bit 16 selects batch mode and bit 18 selects debug mode (debug wins if both are set). The choice persists across other command writes. Status bits 16, 17 and 18 show batch, dedicated and debug respectively. Command bit 10 gives a one-cycle eng_step pulse.
- R9: A write to 0x04 while the state is not idle and the slot is empty fills the slot and sets status bit 3. A further write while the slot is full is ignored. When the state becomes idle with the slot full, the held address is launched at the next edge, as in R4, and bit 3 clears.
- R10: eng_err_info carries the error cause in these fields: [3:0] source, [4] DMA direction, [6:5] DMA size, [9:7] DMA sub-source, [13:10] unit cause index, [15:14] failing unit. On an error it is packed into 0x14 as follows: source in bits 3:0. When the source is 15, the direction goes to bit 8, the size to bits 10:9 and the sub-source to bits 15:13. When the source is 14, the cause index below 12 sets a single bit 16+index, and the unit goes to bits 29:28. All other bits are zero.
- R11: Command bit 9 zeroes the error status and fault address. Command bit 8 alone leaves them unchanged.
- R12: eng_fault while busy captures eng_fault_addr into 0x18.
- R13: Command bit 0 returns the state to idle, empties the slot and zeroes the error status and fault address at that edge. It overrides engine events and descriptor writes in the same cycle, and it pulses eng_abort for one cycle.
- R14: Status bits 11, 10 and 9 mirror eng_active[2], [1] and [0] (cipher, hash, RNG units). Bits 31:24 mirror eng_istate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | BUS_AW | Register byte offset for reads and writes |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt |
| eng_start | output | 1 | One-cycle start pulse to the walker |
| eng_desc | output | AW | Address of the launched descriptor |
| eng_abort | output | 1 | One-cycle engine reset pulse |
| eng_step | output | 1 | One-cycle single-step request |
| ctl_throttle | output | 8 | Throttle setting |
| ctl_burst | output | 8 | Maximum burst setting |
| ctl_reseed | output | 1 | Automatic RNG reseed enable |
| eng_done | input | 1 | Descriptor chain finished |
| eng_err | input | 1 | Engine error pulse |
| eng_err_info | input | 16 | Error cause fields, layout in R10 |
| eng_fault | input | 1 | Hardware fault pulse |
| eng_fault_addr | input | AW | Address associated with the fault |
| eng_next_valid | input | 1 | Walker moved to a new descriptor |
| eng_next_addr | input | AW | Address of that descriptor |
| eng_active | input | 3 | Unit activity flags: cipher, hash, RNG |
| eng_istate | input | 8 | Engine internal state byte |

## Verification
Two functions can land on the same clock edge: an engine outcome and a software action. The bench provokes a completion pulse in the same cycle as a descriptor-address write. It judges the pair by requiring the state to show complete with the slot full, and the parked address to launch after the acknowledge. It also drives an engine error in the same cycle as a reset command, and requires the reset to win: idle state, empty slot and a zero error word. Randomised error codes, with a fixed seed, check the field packing against a bench model written from R10.

// File: rtl/accel_csr_pkg.sv
// Shared types and register layout constants for the engine CSR block.
// Assumes 32-bit registers at byte offsets; offsets fit in 8 bits.
package accel_csr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUSY  = 3'd1,
        ST_ERR   = 3'd2,
        ST_FAULT = 3'd3,
        ST_DONE  = 3'd4
    } eng_state_e;

    typedef enum logic [1:0] {
        MODE_DEDIC = 2'd0,
        MODE_BATCH = 2'd1,
        MODE_DEBUG = 2'd2
    } run_mode_e;

    // Raw error cause fields from the engine (LSB first: src at [3:0]).
    typedef struct packed {
        logic [1:0] unit;
        logic [3:0] cause;
        logic [2:0] dsrc;
        logic [1:0] size;
        logic       dir;
        logic [3:0] src;
    } err_info_t;

    localparam logic [7:0] OFS_VERSION = 8'h00;
    localparam logic [7:0] OFS_DESC    = 8'h04;
    localparam logic [7:0] OFS_CTRL    = 8'h08;
    localparam logic [7:0] OFS_CMD     = 8'h0C;
    localparam logic [7:0] OFS_STAT    = 8'h10;
    localparam logic [7:0] OFS_ERR     = 8'h14;
    localparam logic [7:0] OFS_FADDR   = 8'h18;
    localparam logic [7:0] OFS_CUR     = 8'h1C;
    localparam logic [7:0] OFS_INIT    = 8'h20;

    localparam int CMD_RST    = 0;
    localparam int CMD_CLRINT = 8;
    localparam int CMD_CLRERR = 9;
    localparam int CMD_STEP   = 10;
    localparam int CMD_BATCH  = 16;
    localparam int CMD_DEBUG  = 18;

    localparam logic [3:0] SRC_UNIT = 4'd14;
    localparam logic [3:0] SRC_DMA  = 4'd15;
    localparam int CAUSE_N = 12;

endpackage

// File: rtl/accel_csr_seq.sv
// Engine state tracker, holding slot and descriptor address registers.
// Assumes event inputs are single-cycle pulses; soft_rst has top priority.
module accel_csr_seq
    import accel_csr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          dar_wr,
    input  logic [AW-1:0] dar_data,
    input  logic          clr_any,
    input  logic          ev_done,
    input  logic          ev_err,
    input  logic          ev_fault,
    input  logic          nxt_valid,
    input  logic [AW-1:0] nxt_addr,
    output eng_state_e    state_o,
    output logic          slot_full_o,
    output logic [AW-1:0] held_o,
    output logic [AW-1:0] init_o,
    output logic [AW-1:0] cur_o,
    output logic          start_o,
    output logic          err_cap_o,
    output logic          fault_cap_o
);

    eng_state_e    st;
    logic          full;
    logic [AW-1:0] held, init_a, cur_a;
    logic          start_q;
    logic          idle, busy, launch_held, launch_new, launch, slot_load;
    logic [AW-1:0] launch_addr;

    // Decode which action the current cycle takes
    always_comb begin
        idle        = (st == ST_IDLE);
        busy        = (st == ST_BUSY);
        launch_held = idle && full;
        launch_new  = idle && !full && dar_wr;
        launch      = (launch_held || launch_new) && !soft_rst;
        slot_load   = dar_wr && !full && !idle && !soft_rst;
        launch_addr = launch_held ? held : dar_data;
        err_cap_o   = busy && ev_err && !ev_fault && !soft_rst;
        fault_cap_o = busy && ev_fault && !soft_rst;
    end

    // State, slot and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            full    <= 1'b0;
            held    <= '0;
            init_a  <= '0;
            cur_a   <= '0;
            start_q <= 1'b0;
        end else if (soft_rst) begin
            st      <= ST_IDLE;
            full    <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= launch;
            if (launch) begin
                st     <= ST_BUSY;
                init_a <= launch_addr;
                cur_a  <= launch_addr;
                if (launch_held) full <= 1'b0;
            end else begin
                case (st)
                    ST_BUSY: begin
                        if (ev_fault)      st <= ST_FAULT;
                        else if (ev_err)   st <= ST_ERR;
                        else if (ev_done)  st <= ST_DONE;
                        if (nxt_valid) cur_a <= nxt_addr;
                    end
                    ST_ERR, ST_FAULT, ST_DONE: begin
                        if (clr_any) st <= ST_IDLE;
                    end
                    default: ;
                endcase
            end
            if (slot_load) begin
                held <= dar_data;
                full <= 1'b1;
            end
        end
    end

    assign state_o     = st;
    assign slot_full_o = full;
    assign held_o      = held;
    assign init_o      = init_a;
    assign cur_o       = cur_a;
    assign start_o     = start_q;

endmodule

// File: rtl/accel_csr_errlog.sv
// Packs engine error causes into the error-status word and keeps the
// fault address. Assumes capture and clear are decoded by the caller.
module accel_csr_errlog
    import accel_csr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          clr_err,
    input  logic          err_cap,
    input  err_info_t     info,
    input  logic          fault_cap,
    input  logic [AW-1:0] fault_addr_in,
    output logic [31:0]   errstat_o,
    output logic [AW-1:0] fault_addr_o
);

    logic [CAUSE_N-1:0] cause_oh;
    logic [31:0]        packed_w;
    logic [31:0]        errstat_q;
    logic [AW-1:0]      faddr_q;

    // One decoder leg per unit cause bit
    for (genvar g = 0; g < CAUSE_N; g++) begin : g_cause
        assign cause_oh[g] = (info.cause == 4'(g));
    end

    // Build the error-status word, keeping only fields the source calls for
    always_comb begin
        packed_w       = '0;
        packed_w[3:0]  = info.src;
        if (info.src == SRC_DMA) begin
            packed_w[8]     = info.dir;
            packed_w[10:9]  = info.size;
            packed_w[15:13] = info.dsrc;
        end
        if (info.src == SRC_UNIT) begin
            packed_w[16 +: CAUSE_N] = cause_oh;
            packed_w[29:28]         = info.unit;
        end
    end

    // Error-status and fault-address registers
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            errstat_q <= '0;
            faddr_q   <= '0;
        end else begin
            if (err_cap)      errstat_q <= packed_w;
            else if (clr_err) errstat_q <= '0;
            if (fault_cap)    faddr_q <= fault_addr_in;
            else if (clr_err) faddr_q <= '0;
        end
    end

    assign errstat_o    = errstat_q;
    assign fault_addr_o = faddr_q;

endmodule

// File: rtl/accel_csr_ctrl.sv
// Control register, run-mode latch and command pulse outputs.
// Assumes the command register itself stores nothing (self-clearing).
module accel_csr_ctrl
    import accel_csr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic        cmd_wr,
    input  logic [31:0] wdata,
    output logic [7:0]  throttle_o,
    output logic [7:0]  burst_o,
    output logic        reseed_o,
    output logic        int_en_o,
    output run_mode_e   mode_o,
    output logic        step_o,
    output logic        abort_o
);

    run_mode_e mode_q;

    // Writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            throttle_o <= '0;
            burst_o    <= '0;
            reseed_o   <= 1'b0;
            int_en_o   <= 1'b0;
        end else if (ctrl_wr) begin
            throttle_o <= wdata[31:24];
            burst_o    <= wdata[23:16];
            reseed_o   <= wdata[7];
            int_en_o   <= wdata[4];
        end
    end

    // Run mode latch; debug outranks batch
    always_ff @(posedge clk) begin
        if (!rst_n)                            mode_q <= MODE_DEDIC;
        else if (cmd_wr && wdata[CMD_DEBUG])   mode_q <= MODE_DEBUG;
        else if (cmd_wr && wdata[CMD_BATCH])   mode_q <= MODE_BATCH;
    end

    // One-cycle command pulses toward the engine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_o  <= 1'b0;
            abort_o <= 1'b0;
        end else begin
            step_o  <= cmd_wr && wdata[CMD_STEP];
            abort_o <= cmd_wr && wdata[CMD_RST];
        end
    end

    assign mode_o = mode_q;

endmodule

// File: rtl/accel_csr.sv
// Top of the engine CSR block: bus decode, read mux, interrupt.
// Assumes one write per bus_wr cycle and AW no wider than 32.
module accel_csr
    import accel_csr_pkg::*;
#(
    parameter int          BUS_AW  = 8,
    parameter int          AW      = 32,
    parameter logic [31:0] VERSION = 32'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              eng_start,
    output logic [AW-1:0]     eng_desc,
    output logic              eng_abort,
    output logic              eng_step,
    output logic [7:0]        ctl_throttle,
    output logic [7:0]        ctl_burst,
    output logic              ctl_reseed,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic [15:0]       eng_err_info,
    input  logic              eng_fault,
    input  logic [AW-1:0]     eng_fault_addr,
    input  logic              eng_next_valid,
    input  logic [AW-1:0]     eng_next_addr,
    input  logic [2:0]        eng_active,
    input  logic [7:0]        eng_istate
);

    logic          dar_wr, ctrl_wr, cmd_wr, soft_rst, clr_int, clr_err, clr_any;
    eng_state_e    st;
    logic          slot_full, err_cap, fault_cap, int_en, pending;
    logic [AW-1:0] held, init_a, cur_a, faddr;
    logic [31:0]   errstat, status_w, ctrl_w;
    run_mode_e     mode;

    // Write decode and command bit extraction
    always_comb begin
        dar_wr   = bus_wr && (bus_addr == BUS_AW'(OFS_DESC));
        ctrl_wr  = bus_wr && (bus_addr == BUS_AW'(OFS_CTRL));
        cmd_wr   = bus_wr && (bus_addr == BUS_AW'(OFS_CMD));
        soft_rst = cmd_wr && bus_wdata[CMD_RST];
        clr_int  = cmd_wr && bus_wdata[CMD_CLRINT];
        clr_err  = cmd_wr && bus_wdata[CMD_CLRERR];
        clr_any  = clr_int || clr_err;
    end

    accel_csr_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_rst   (soft_rst),
        .dar_wr     (dar_wr),
        .dar_data   (bus_wdata[AW-1:0]),
        .clr_any    (clr_any),
        .ev_done    (eng_done),
        .ev_err     (eng_err),
        .ev_fault   (eng_fault),
        .nxt_valid  (eng_next_valid),
        .nxt_addr   (eng_next_addr),
        .state_o    (st),
        .slot_full_o(slot_full),
        .held_o     (held),
        .init_o     (init_a),
        .cur_o      (cur_a),
        .start_o    (eng_start),
        .err_cap_o  (err_cap),
        .fault_cap_o(fault_cap)
    );

    accel_csr_errlog #(.AW(AW)) u_errlog (
        .clk          (clk),
        .rst_n        (rst_n),
        .soft_rst     (soft_rst),
        .clr_err      (clr_err),
        .err_cap      (err_cap),
        .info         (err_info_t'(eng_err_info)),
        .fault_cap    (fault_cap),
        .fault_addr_in(eng_fault_addr),
        .errstat_o    (errstat),
        .fault_addr_o (faddr)
    );

    accel_csr_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .cmd_wr    (cmd_wr),
        .wdata     (bus_wdata),
        .throttle_o(ctl_throttle),
        .burst_o   (ctl_burst),
        .reseed_o  (ctl_reseed),
        .int_en_o  (int_en),
        .mode_o    (mode),
        .step_o    (eng_step),
        .abort_o   (eng_abort)
    );

    // Assemble status and control read words; level interrupt
    always_comb begin
        pending  = (st == ST_DONE) || (st == ST_ERR) || (st == ST_FAULT);
        irq      = int_en && pending;
        status_w = {eng_istate, 5'b0,
                    mode == MODE_DEBUG, mode == MODE_DEDIC, mode == MODE_BATCH,
                    4'b0, eng_active, 4'b0,
                    (st == ST_ERR) || (st == ST_FAULT), slot_full, st};
        ctrl_w   = {ctl_throttle, ctl_burst, 8'b0, ctl_reseed, 2'b0, int_en, 4'b0};
    end

    // Read multiplexer
    always_comb begin
        case (bus_addr)
            BUS_AW'(OFS_VERSION): bus_rdata = VERSION;
            BUS_AW'(OFS_DESC):    bus_rdata = 32'(held);
            BUS_AW'(OFS_CTRL):    bus_rdata = ctrl_w;
            BUS_AW'(OFS_CMD):     bus_rdata = '0;
            BUS_AW'(OFS_STAT):    bus_rdata = status_w;
            BUS_AW'(OFS_ERR):     bus_rdata = errstat;
            BUS_AW'(OFS_FADDR):   bus_rdata = 32'(faddr);
            BUS_AW'(OFS_CUR):     bus_rdata = 32'(cur_a);
            BUS_AW'(OFS_INIT):    bus_rdata = 32'(init_a);
            default:              bus_rdata = '0;
        endcase
    end

    assign eng_desc = init_a;

endmodule

// File: rtl/accel_csr_chk.sv
// Temporal checks on the CSR block, bound into accel_csr.
module accel_csr_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    st,
    input logic          slot_full,
    input logic [AW-1:0] held,
    input logic          irq,
    input logic          eng_start,
    input logic          dar_wr,
    input logic          soft_rst,
    input logic          clr_any,
    input logic          eng_done,
    input logic          eng_err,
    input logic          eng_fault,
    input logic [31:0]   errstat
);

    // R4
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd0 && !slot_full && dar_wr && !soft_rst) |=> (st == 3'd1 && eng_start));

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> st == 3'd1);

    // R7
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st == 3'd2 || st == 3'd3 || st == 3'd4));

    // R7
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 3'd2 || st == 3'd3 || st == 3'd4) && clr_any && !soft_rst) |=> st == 3'd0);

    // R9
    slot_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full && dar_wr && st != 3'd0 && !soft_rst) |=> (slot_full && $stable(held)));

    // R13
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (st == 3'd0 && !slot_full && errstat == 32'd0));

    // R6
    done_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && eng_done && !eng_err && !eng_fault && !soft_rst) |=> st == 3'd4);

    // R6
    fault_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && eng_fault && !soft_rst) |=> st == 3'd3);

endmodule

bind accel_csr accel_csr_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .slot_full(slot_full),
    .held     (held),
    .irq      (irq),
    .eng_start(eng_start),
    .dar_wr   (dar_wr),
    .soft_rst (soft_rst),
    .clr_any  (clr_any),
    .eng_done (eng_done),
    .eng_err  (eng_err),
    .eng_fault(eng_fault),
    .errstat  (errstat)
);

// File: tb/test_accel_csr.sv
`timescale 1ns/1ps
// Self-checking bench: directed corners plus seeded random error codes.
module test_accel_csr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, eng_start, eng_abort, eng_step, ctl_reseed;
    logic [31:0] eng_desc;
    logic [7:0]  ctl_throttle, ctl_burst;
    logic        eng_done = 0, eng_err = 0, eng_fault = 0, eng_next_valid = 0;
    logic [15:0] eng_err_info = '0;
    logic [31:0] eng_fault_addr = '0, eng_next_addr = '0;
    logic [2:0]  eng_active = '0;
    logic [7:0]  eng_istate = '0;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    accel_csr i_accel_csr (.*);

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        cyc();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic pulse_done();
        eng_done = 1'b1; cyc(); eng_done = 1'b0;
    endtask

    // Expected error-status word per R10
    function automatic logic [31:0] exp_err(input logic [15:0] inf);
        logic [31:0] w = '0;
        w[3:0] = inf[3:0];
        if (inf[3:0] == 4'd15) begin
            w[8] = inf[4]; w[10:9] = inf[6:5]; w[15:13] = inf[9:7];
        end
        if (inf[3:0] == 4'd14) begin
            if (inf[13:10] < 4'd12) w[16 + inf[13:10]] = 1'b1;
            w[29:28] = inf[15:14];
        end
        return w;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();

        // R2 reset state, R1 map
        chk_rd("R2 status", 8'h10, 32'h0002_0000);
        chk_rd("R2 errstat", 8'h14, 32'h0);
        chk_rd("R2 ctrl", 8'h08, 32'h0);
        chk("R2 irq", {31'b0, irq}, 32'h0);
        chk_rd("R1 version", 8'h00, 32'd3);
        chk_rd("R1 unmapped", 8'h24, 32'h0);

        // R3 control fields
        wr(8'h08, 32'hFFFF_FFFF);
        chk_rd("R3 ctrl readback", 8'h08, 32'hFFFF_0090);
        chk("R3 outputs", {15'b0, ctl_reseed, ctl_throttle, ctl_burst}, 32'h0001_FFFF);
        wr(8'h08, 32'h1234_0010);
        chk_rd("R3 ctrl readback2", 8'h08, 32'h1234_0010);

        // R4 start from idle
        wr(8'h04, 32'h1000);
        chk("R4 start pulse", {31'b0, eng_start}, 32'h1);
        chk("R4 eng_desc", eng_desc, 32'h1000);
        chk_rd("R4 status busy", 8'h10, 32'h0002_0001);
        chk_rd("R4 init", 8'h20, 32'h1000);
        chk_rd("R4 cur", 8'h1C, 32'h1000);
        cyc();
        chk("R4 start one cycle", {31'b0, eng_start}, 32'h0);

        // R5 progress
        eng_next_valid = 1; eng_next_addr = 32'h1040; cyc(); eng_next_valid = 0;
        chk_rd("R5 cur", 8'h1C, 32'h1040);
        chk_rd("R5 init kept", 8'h20, 32'h1000);

        // R7 clear while busy has no effect
        wr(8'h0C, 32'h300);
        chk_rd("R7 clear in busy", 8'h10, 32'h0002_0001);

        // R6 done
        pulse_done();
        chk_rd("R6 done state", 8'h10, 32'h0002_0004);
        chk("R7 irq on done", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h100);
        chk_rd("R7 cleared", 8'h10, 32'h0002_0000);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        chk_rd("R8 cmd reads zero", 8'h0C, 32'h0);

        // R7 interrupt enable gating
        wr(8'h08, 32'h0);
        wr(8'h04, 32'h1100);
        pulse_done();
        chk("R7 irq masked", {31'b0, irq}, 32'h0);
        wr(8'h08, 32'h10);
        chk("R7 irq unmasked", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h200);
        chk_rd("R7 clear bit9", 8'h10, 32'h0002_0000);

        // R9 holding slot
        wr(8'h04, 32'h2000);
        wr(8'h04, 32'h3000);
        chk_rd("R9 slot full", 8'h10, 32'h0002_0009);
        wr(8'h04, 32'h4000);
        chk_rd("R9 second write ignored", 8'h04, 32'h3000);
        pulse_done();
        chk_rd("R9 done with slot", 8'h10, 32'h0002_000C);
        wr(8'h0C, 32'h100);
        chk_rd("R9 idle then launch", 8'h10, 32'h0002_0008);
        cyc();
        chk_rd("R9 launched", 8'h10, 32'h0002_0001);
        chk_rd("R9 init held", 8'h20, 32'h3000);
        chk("R9 eng_desc", eng_desc, 32'h3000);
        pulse_done();
        wr(8'h0C, 32'h100);

        // Same cycle: done and descriptor write
        wr(8'h04, 32'h5000);
        eng_done = 1'b1;
        wr(8'h04, 32'h6000);
        eng_done = 1'b0;
        chk_rd("R9 done+write same cycle", 8'h10, 32'h0002_000C);
        wr(8'h0C, 32'h100);
        cyc();
        chk_rd("R9 parked launch", 8'h20, 32'h6000);

        // R13 reset command beats error in same cycle; slot emptied
        wr(8'h04, 32'h7000);
        eng_err = 1'b1; eng_err_info = 16'h000F;
        wr(8'h0C, 32'h1);
        eng_err = 1'b0;
        chk("R13 abort pulse", {31'b0, eng_abort}, 32'h1);
        chk_rd("R13 status idle", 8'h10, 32'h0002_0000);
        chk_rd("R13 errstat zero", 8'h14, 32'h0);
        cyc();
        chk("R13 abort one cycle", {31'b0, eng_abort}, 32'h0);
        chk_rd("R13 no relaunch", 8'h10, 32'h0002_0000);

        // R6 priority fault over error, R12 capture
        wr(8'h04, 32'h8000);
        eng_fault = 1; eng_err = 1; eng_fault_addr = 32'hDEAD_0040;
        cyc();
        eng_fault = 0; eng_err = 0;
        chk_rd("R6 fault priority", 8'h10, 32'h0002_0013);
        chk_rd("R12 fault addr", 8'h18, 32'hDEAD_0040);
        wr(8'h0C, 32'h200);
        chk_rd("R11 fault addr cleared", 8'h18, 32'h0);

        // R10/R11 random error codes
        for (int i = 0; i < 60; i++) begin
            logic [15:0] inf;
            logic [31:0] ex;
            int sel;
            inf = 16'($urandom);
            sel = $urandom % 4;
            if (sel == 0) inf[3:0] = 4'd14;
            else if (sel == 1) inf[3:0] = 4'd15;
            ex = exp_err(inf);
            wr(8'h04, 32'h100 * (i + 1));
            eng_err_info = inf; eng_err = 1; cyc(); eng_err = 0;
            chk_rd("R6 error state", 8'h10, 32'h0002_0012);
            chk_rd("R10 packing", 8'h14, ex);
            if ($urandom % 2 == 0) begin
                wr(8'h0C, 32'h100);
                chk_rd("R11 bit8 keeps errstat", 8'h14, ex);
                wr(8'h0C, 32'h200);
            end else begin
                wr(8'h0C, 32'h200);
            end
            chk_rd("R11 bit9 zeroes errstat", 8'h14, 32'h0);
            chk_rd("R7 idle after clear", 8'h10, 32'h0002_0000);
        end

        // R8 modes and step
        wr(8'h0C, 32'h0001_0000);
        chk_rd("R8 batch", 8'h10, 32'h0001_0000);
        wr(8'h0C, 32'h0005_0000);
        chk_rd("R8 debug wins", 8'h10, 32'h0004_0000);
        wr(8'h0C, 32'h400);
        chk("R8 step pulse", {31'b0, eng_step}, 32'h1);
        chk_rd("R8 mode persists", 8'h10, 32'h0004_0000);

        // R14 status mirrors
        eng_active = 3'b101; eng_istate = 8'hA5;
        chk_rd("R14 mirrors", 8'h10, 32'hA504_0A00);

        finished = 1;
        summary();
        $finish;
    end

endmodule